// File: doc/BRIEF.md
# I2C SCL Clock Timing Generator

This block turns a peripheral clock frequency and a requested I2C bus speed into the timing values a serial-clock generator needs. These values are a 12-bit divider, a fast-mode flag, a duty flag and a rise-time limit. From those values it drives a free-running SCL enable waveform whose low and high phases are counted in peripheral clock cycles. Speeds up to 100 kHz use standard timing with equal low and high phases. Speeds above 100 kHz and up to 400 kHz use fast timing, and a select input chooses a 2:1 or a 16:9 low-to-high ratio.

A configuration is taken on a one-cycle load strobe. An iterative divider then computes the new values, and the result is committed in a single cycle. During the computation the waveform generator is stopped with SCL released high. Once the commit is done, the generator returns to whatever state the user enable asks for. A configuration that is out of range is rejected: an error flag is raised and the last good timing stays in force. Clock stretching and arbitration are handled elsewhere.

Top module: `i2c_scl_timing`

## Requirements
- R1: For a speed of 1 to 100 kHz, the divider is floor(pclk_mhz*1000 / (2*speed_khz)), with fast_mode=0 and duty_flag=0; duty_sel has no effect. A quotient below 4 is raised to 4.
- R2: After reset: div_val=0, fast_mode=0, duty_flag=0, rise_limit=0, cfg_err=0, cfg_busy=0 and scl_out=1.
- R3: For a speed of 101 to 400 kHz with duty_sel=0, the divider is floor(pclk_mhz*1000 / (3*speed_khz)), with fast_mode=1 and duty_flag=0.
- R4: For a speed of 101 to 400 kHz with duty_sel=1, the divider is floor(pclk_mhz*1000 / (25*speed_khz)), with fast_mode=1 and duty_flag=1.
- R5: In fast timing, a quotient of 0 is raised to 1.
- R6: If the divider after the minimum rule exceeds 4095, the configuration is rejected. cfg_err becomes 1, and div_val, fast_mode, duty_flag and rise_limit keep their previous values.
- R7: A configuration with pclk_mhz outside 2..36 or speed_khz outside 1..400 is rejected in the same way as in R6. An accepted configuration clears cfg_err.
- R8: rise_limit is pclk_mhz+1 in standard timing and floor(pclk_mhz*3/10)+1 in fast timing.
- R9: cfg_busy rises on the edge that samples cfg_load and falls on the edge that commits the result. A load strobe that arrives while cfg_busy is high is ignored. From the second edge after the load until the commit, scl_out is held at 1. After the commit, the generator follows gen_en again.
- R10: With gen_en=1, scl_out is low for div and high for div cycles in standard timing. It is low for 2*div and high for div cycles in fast timing with duty_flag=0, and low for 16*div and high for 9*div cycles with duty_flag=1.
- R11: scl_out is 1 while gen_en=0 or div_val=0. On the first edge at which it is enabled, it drops to 0 and begins with a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle strobe that takes a new configuration |
| pclk_mhz | input | 6 | Peripheral clock frequency in MHz |
| speed_khz | input | 9 | Requested bus speed in kHz |
| duty_sel | input | 1 | Fast-mode ratio: 0 selects 2:1, 1 selects 16:9 |
| gen_en | input | 1 | User enable of the SCL waveform |
| cfg_busy | output | 1 | Configuration is being computed |
| cfg_err | output | 1 | The last configuration was rejected |
| div_val | output | 12 | Committed divider |
| fast_mode | output | 1 | Committed fast-timing flag |
| duty_flag | output | 1 | Committed 16:9 flag |
| rise_limit | output | 6 | Committed rise-time limit count |
| scl_out | output | 1 | SCL enable waveform, 1 = released high |

## Verification
Directed configurations cover each timing regime. A standard one, a 2:1 one and a 16:9 one are each followed by a measurement of the waveform's low and high phase lengths, so a swapped ratio or an off-by-one phase shows up in the cycle counts. Corner cases separate the two minimum rules, the 4095 overflow and each out-of-range input from a normal commit, and they check that the previous timing survives each rejection. A load issued while a computation is running checks that SCL is held high and that the second strobe is lost. Seeded random configurations, some valid and some invalid, are then compared with a bench model of the divider, the minimum and the rise-time rules.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  localparam int KHZ_PER_MHZ  = 1000;
  localparam int STD_MAX_KHZ  = 100;
  localparam int FAST_MAX_KHZ = 400;
  localparam int PCLK_MIN_MHZ = 2;
  localparam int PCLK_MAX_MHZ = 36;
  localparam int STD_MULT     = 2;
  localparam int FAST_MULT_2  = 3;
  localparam int FAST_MULT_16 = 25;
  localparam int STD_MIN_DIV  = 4;
  localparam int FAST_MIN_DIV = 1;

  typedef enum logic [1:0] {
    RATIO_1_1  = 2'd0,
    RATIO_2_1  = 2'd1,
    RATIO_16_9 = 2'd2
  } ratio_e;

endpackage

// File: rtl/scl_seq_divider.sv
module scl_seq_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_r, r_r, d_r, n_r;
  logic [CW-1:0] cnt_r;
  logic          act_r, done_r;
  logic [W:0]    trial;
  logic          fits;

  assign trial = {r_r, q_r[W-1]};
  assign fits  = (trial >= {1'b0, d_r});

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r    <= '0;
      r_r    <= '0;
      d_r    <= '0;
      n_r    <= '0;
      cnt_r  <= '0;
      act_r  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start && !act_r) begin
        q_r   <= num;
        n_r   <= num;
        r_r   <= '0;
        d_r   <= den;
        cnt_r <= CW'(W);
        act_r <= 1'b1;
      end else if (act_r) begin
        if (fits) begin
          r_r <= W'(trial - {1'b0, d_r});
          q_r <= {q_r[W-2:0], 1'b1};
        end else begin
          r_r <= trial[W-1:0];
          q_r <= {q_r[W-2:0], 1'b0};
        end
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CW'(1)) begin
          act_r  <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign done = done_r;
  assign quo  = q_r;

  // The quotient and remainder reconstruct the numerator exactly (basis of R1, R3, R4)
  assert_div_exact_R1: assert property (@(posedge clk) disable iff (rst)
    (done_r && d_r != '0) |->
      (((2*W)'(q_r) * (2*W)'(d_r) + (2*W)'(r_r)) == (2*W)'(n_r)) && (r_r < d_r));

  assert_one_shot_done_R9: assert property (@(posedge clk) disable iff (rst)
    done_r |=> !done_r);

endmodule

// File: rtl/scl_cfg_calc.sv
module scl_cfg_calc
  import i2c_scl_pkg::*;
#(
  parameter int PCLK_W = 6,
  parameter int SPD_W  = 9,
  parameter int DIV_W  = 12,
  parameter int RISE_W = 6,
  parameter int NUM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PCLK_W-1:0] pclk_mhz,
  input  logic [SPD_W-1:0]  speed_khz,
  input  logic              duty_sel,
  output logic              busy,
  output logic              commit,
  output logic              accept,
  output logic [DIV_W-1:0]  div_out,
  output logic              fs_out,
  output logic              duty_out,
  output logic [RISE_W-1:0] rise_out
);
  localparam int RT_W = PCLK_W + 2;

  logic              busy_r;
  logic [PCLK_W-1:0] pclk_r;
  logic [SPD_W-1:0]  spd_r;
  logic              fast_r, duty_r;
  logic              take;
  logic              in_fast;
  logic [NUM_W-1:0]  num, den, mult;
  logic              div_done;
  logic [NUM_W-1:0]  quo, clamped;
  logic              range_ok, fit_ok;
  logic [RT_W-1:0]   rise_fast;

  assign take    = load && !busy_r;
  assign in_fast = (int'(speed_khz) > STD_MAX_KHZ);

  always_comb begin
    if (!in_fast)      mult = NUM_W'(STD_MULT);
    else if (duty_sel) mult = NUM_W'(FAST_MULT_16);
    else               mult = NUM_W'(FAST_MULT_2);
  end

  assign num = NUM_W'(pclk_mhz) * NUM_W'(KHZ_PER_MHZ);
  assign den = NUM_W'(speed_khz) * mult;

  scl_seq_divider #(.W(NUM_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (take),
    .num   (num),
    .den   (den),
    .done  (div_done),
    .quo   (quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_r <= 1'b0;
      pclk_r <= '0;
      spd_r  <= '0;
      fast_r <= 1'b0;
      duty_r <= 1'b0;
    end else if (take) begin
      busy_r <= 1'b1;
      pclk_r <= pclk_mhz;
      spd_r  <= speed_khz;
      fast_r <= in_fast;
      duty_r <= in_fast && duty_sel;
    end else if (div_done) begin
      busy_r <= 1'b0;
    end
  end

  // Minimum rules per timing regime
  always_comb begin
    if (fast_r)
      clamped = (quo < NUM_W'(FAST_MIN_DIV)) ? NUM_W'(FAST_MIN_DIV) : quo;
    else
      clamped = (quo < NUM_W'(STD_MIN_DIV)) ? NUM_W'(STD_MIN_DIV) : quo;
  end

  assign fit_ok   = (clamped >> DIV_W) == '0;
  assign range_ok = (int'(pclk_r) >= PCLK_MIN_MHZ) && (int'(pclk_r) <= PCLK_MAX_MHZ) &&
                    (spd_r != '0) && (int'(spd_r) <= FAST_MAX_KHZ);
  assign rise_fast = (RT_W'(pclk_r) * RT_W'(3)) / RT_W'(10);

  assign busy     = busy_r;
  assign commit   = div_done;
  assign accept   = range_ok && fit_ok;
  assign div_out  = clamped[DIV_W-1:0];
  assign fs_out   = fast_r;
  assign duty_out = duty_r;
  assign rise_out = fast_r ? RISE_W'(rise_fast + RT_W'(1)) : RISE_W'(pclk_r + PCLK_W'(1));

  assert_commit_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
    div_done |-> busy_r);

  assert_load_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_r && !div_done) |=> (busy_r && $stable(pclk_r) && $stable(spd_r)));

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [LEN_W-1:0] low_len,
  input  logic [LEN_W-1:0] high_len,
  output logic             scl
);
  logic             go;
  logic             run_r, scl_r;
  logic [LEN_W-1:0] cnt_r;

  assign go = en && (low_len != '0) && (high_len != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_r <= 1'b0;
      scl_r <= 1'b1;
      cnt_r <= '0;
    end else if (!go) begin
      run_r <= 1'b0;
      scl_r <= 1'b1;
      cnt_r <= '0;
    end else if (!run_r) begin
      run_r <= 1'b1;
      scl_r <= 1'b0;
      cnt_r <= low_len - 1'b1;
    end else if (cnt_r == '0) begin
      scl_r <= !scl_r;
      cnt_r <= scl_r ? (low_len - 1'b1) : (high_len - 1'b1);
    end else begin
      cnt_r <= cnt_r - 1'b1;
    end
  end

  assign scl = scl_r;

  assert_idle_high_R11: assert property (@(posedge clk) disable iff (rst)
    !go |=> scl_r);

  assert_start_low_R11: assert property (@(posedge clk) disable iff (rst)
    (go && !run_r) |=> !scl_r);

  assert_hold_phase_R10: assert property (@(posedge clk) disable iff (rst)
    (go && run_r && cnt_r != '0) |=> $stable(scl_r));

endmodule

// File: rtl/i2c_scl_timing.sv
module i2c_scl_timing
  import i2c_scl_pkg::*;
#(
  parameter int PCLK_W = 6,
  parameter int SPD_W  = 9,
  parameter int DIV_W  = 12,
  parameter int RISE_W = 6,
  parameter int NUM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [PCLK_W-1:0] pclk_mhz,
  input  logic [SPD_W-1:0]  speed_khz,
  input  logic              duty_sel,
  input  logic              gen_en,
  output logic              cfg_busy,
  output logic              cfg_err,
  output logic [DIV_W-1:0]  div_val,
  output logic              fast_mode,
  output logic              duty_flag,
  output logic [RISE_W-1:0] rise_limit,
  output logic              scl_out
);
  localparam int LEN_W = DIV_W + 4;

  logic              busy, commit, accept;
  logic [DIV_W-1:0]  c_div;
  logic              c_fs, c_duty;
  logic [RISE_W-1:0] c_rise;

  logic [DIV_W-1:0]  div_q;
  logic              fs_q, duty_q, err_q;
  logic [RISE_W-1:0] rise_q;

  ratio_e            ratio;
  logic [LEN_W-1:0]  div_ext, low_len, high_len;

  scl_cfg_calc #(
    .PCLK_W (PCLK_W),
    .SPD_W  (SPD_W),
    .DIV_W  (DIV_W),
    .RISE_W (RISE_W),
    .NUM_W  (NUM_W)
  ) u_calc (
    .clk       (clk),
    .rst       (rst),
    .load      (cfg_load),
    .pclk_mhz  (pclk_mhz),
    .speed_khz (speed_khz),
    .duty_sel  (duty_sel),
    .busy      (busy),
    .commit    (commit),
    .accept    (accept),
    .div_out   (c_div),
    .fs_out    (c_fs),
    .duty_out  (c_duty),
    .rise_out  (c_rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      fs_q   <= 1'b0;
      duty_q <= 1'b0;
      rise_q <= '0;
      err_q  <= 1'b0;
    end else if (commit) begin
      err_q <= !accept;
      if (accept) begin
        div_q  <= c_div;
        fs_q   <= c_fs;
        duty_q <= c_duty;
        rise_q <= c_rise;
      end
    end
  end

  always_comb begin
    if (!fs_q)       ratio = RATIO_1_1;
    else if (duty_q) ratio = RATIO_16_9;
    else             ratio = RATIO_2_1;
  end

  assign div_ext = LEN_W'(div_q);

  always_comb begin
    case (ratio)
      RATIO_2_1: begin
        low_len  = div_ext << 1;
        high_len = div_ext;
      end
      RATIO_16_9: begin
        low_len  = div_ext << 4;
        high_len = (div_ext << 3) + div_ext;
      end
      default: begin
        low_len  = div_ext;
        high_len = div_ext;
      end
    endcase
  end

  scl_phase_gen #(.LEN_W(LEN_W)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .en       (gen_en && !busy),
    .low_len  (low_len),
    .high_len (high_len),
    .scl      (scl_out)
  );

  assign cfg_busy   = busy;
  assign cfg_err    = err_q;
  assign div_val    = div_q;
  assign fast_mode  = fs_q;
  assign duty_flag  = duty_q;
  assign rise_limit = rise_q;

  assert_std_floor_R1: assert property (@(posedge clk) disable iff (rst)
    (!fs_q && div_q != '0) |-> (div_q >= DIV_W'(STD_MIN_DIV)));

  assert_fast_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    fs_q |-> (div_q != '0));

  assert_duty_needs_fast_R4: assert property (@(posedge clk) disable iff (rst)
    duty_q |-> fs_q);

  assert_reject_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (commit && !accept) |=> (cfg_err && $stable(div_q) && $stable(fs_q) &&
                             $stable(duty_q) && $stable(rise_q)));

  assert_busy_scl_high_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> scl_out);

endmodule

// File: tb/i2c_scl_timing_test.sv
module i2c_scl_timing_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0;
  logic [5:0]  pclk_mhz = '0;
  logic [8:0]  speed_khz = '0;
  logic        duty_sel = 1'b0;
  logic        gen_en = 1'b0;
  logic        cfg_busy, cfg_err, fast_mode, duty_flag, scl_out;
  logic [11:0] div_val;
  logic [5:0]  rise_limit;

  int n_chk = 0;
  int n_err = 0;

  // expected committed state
  int m_div = 0, m_fs = 0, m_duty = 0, m_rise = 0, m_err = 0;

  always #2 clk = ~clk;

  i2c_scl_timing uut (
    .clk        (clk),
    .rst        (rst),
    .cfg_load   (cfg_load),
    .pclk_mhz   (pclk_mhz),
    .speed_khz  (speed_khz),
    .duty_sel   (duty_sel),
    .gen_en     (gen_en),
    .cfg_busy   (cfg_busy),
    .cfg_err    (cfg_err),
    .div_val    (div_val),
    .fast_mode  (fast_mode),
    .duty_flag  (duty_flag),
    .rise_limit (rise_limit),
    .scl_out    (scl_out)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Model of the requirements: updates the expected committed state
  task automatic model(input int p, input int s, input int d);
    int fast, k, q, ok, rise;
    fast = (s > 100);
    k = !fast ? 2 : (d != 0 ? 25 : 3);
    q = (s == 0) ? 100000 : (p * 1000) / (s * k);
    if (fast && q < 1) q = 1;
    if (!fast && q < 4) q = 4;
    rise = fast ? (p * 3) / 10 + 1 : p + 1;
    ok = (p >= 2) && (p <= 36) && (s >= 1) && (s <= 400) && (q <= 4095);
    m_err = !ok;
    if (ok) begin
      m_div = q; m_fs = fast; m_duty = fast && (d != 0); m_rise = rise;
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (cfg_busy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic check_outputs(input string req);
    chk(req, "cfg_err", cfg_err, m_err);
    chk(req, "div_val", div_val, m_div);
    chk(req, "fast_mode", fast_mode, m_fs);
    chk(req, "duty_flag", duty_flag, m_duty);
    chk(req, "rise_limit", rise_limit, m_rise);
  endtask

  task automatic apply(input int p, input int s, input int d, input string req);
    @(negedge clk);
    pclk_mhz = 6'(p); speed_khz = 9'(s); duty_sel = d[0]; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    chk("R9", "busy after load", cfg_busy, 1);
    wait_idle();
    model(p, s, d);
    check_outputs(req);
  endtask

  // Enable the waveform and measure its first low and high phase
  task automatic measure(input int exp_low, input int exp_high, input string req);
    int nl, nh;
    @(negedge clk);
    chk("R11", "idle scl", scl_out, 1);
    gen_en = 1'b1;
    @(negedge clk);
    chk("R11", "first phase low", scl_out, 0);
    nl = 1;
    forever begin
      @(negedge clk);
      if (scl_out == 1'b0 && nl < 70000) nl++;
      else break;
    end
    nh = 1;
    forever begin
      @(negedge clk);
      if (scl_out == 1'b1 && nh < 70000) nh++;
      else break;
    end
    chk(req, "low cycles", nl, exp_low);
    chk(req, "high cycles", nh, exp_high);
    gen_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R11", "scl high after disable", scl_out, 1);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    chk("R2", "div_val", div_val, 0);
    chk("R2", "fast_mode", fast_mode, 0);
    chk("R2", "duty_flag", duty_flag, 0);
    chk("R2", "rise_limit", rise_limit, 0);
    chk("R2", "cfg_err", cfg_err, 0);
    chk("R2", "cfg_busy", cfg_busy, 0);
    chk("R2", "scl_out", scl_out, 1);
    // R11: div 0 keeps SCL high even when enabled
    gen_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "scl with zero divider", scl_out, 1);
    gen_en = 1'b0;

    // R1 standard, R8 rise, R10 1:1 phases
    apply(8, 100, 0, "R1");
    chk("R8", "std rise", rise_limit, 9);
    measure(40, 40, "R10");
    // R1 duty_sel ignored in standard timing
    apply(8, 50, 1, "R1");
    chk("R1", "duty ignored", duty_flag, 0);
    // R3 fast 2:1
    apply(8, 400, 0, "R3");
    chk("R8", "fast rise", rise_limit, 3);
    measure(12, 6, "R10");
    // R4 fast 16:9
    apply(36, 400, 1, "R4");
    chk("R4", "div", div_val, 3);
    measure(48, 27, "R10");
    // R5 fast minimum
    apply(2, 400, 1, "R5");
    chk("R5", "div forced", div_val, 1);
    // R6 overflow rejected, previous kept; edge just fitting
    apply(36, 4, 0, "R6");
    chk("R6", "err raised", cfg_err, 1);
    apply(36, 5, 0, "R6");
    chk("R6", "fits", div_val, 3600);
    // R7 range rejections
    apply(40, 100, 0, "R7");
    apply(1, 100, 0, "R7");
    apply(8, 0, 0, "R7");
    apply(8, 401, 1, "R7");
    chk("R7", "err on speed 401", cfg_err, 1);
    apply(2, 1, 0, "R7");
    chk("R7", "err cleared", cfg_err, 0);

    // R9: load while running, SCL held, second load ignored, resume
    apply(8, 400, 0, "R3");
    gen_en = 1'b1;
    repeat (5) @(negedge clk);
    pclk_mhz = 6'd20; speed_khz = 9'd100; duty_sel = 1'b0; cfg_load = 1'b1;
    @(negedge clk);
    pclk_mhz = 6'd36; speed_khz = 9'd4; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    chk("R9", "busy held", cfg_busy, 1);
    chk("R9", "scl high while busy", scl_out, 1);
    wait_idle();
    model(20, 100, 0);
    check_outputs("R9");
    @(negedge clk);
    chk("R9", "scl resumes low", scl_out, 0);
    gen_en = 1'b0;
    repeat (2) @(negedge clk);

    // Random configurations
    for (int i = 0; i < 60; i++) begin
      int p, s, d;
      p = $urandom_range(0, 40);
      s = $urandom_range(0, 420);
      d = $urandom_range(0, 1);
      if (s > 100) apply(p, s, d, d != 0 ? "R4" : "R3");
      else apply(p, s, d, "R1");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule